// File: doc/BRIEF.md
# Polarity-Selectable Interrupt Channel Combiner

This block takes four interrupt source levels, one from bit 0 of the third byte group of each of four 24-bit digital ports, and turns them into a single active-low, level-style interrupt request for a host. Each source first passes through a two-flop synchronizer. A per-channel polarity bit then picks the level or its inverse, and a per-channel enable bit gates the result. The four active-high channels have equal priority and are OR-combined into one registered request.

Software uses the block to catch both edges of a source. It reads the synchronized source levels, compares them with a saved copy to see which channels moved, services them, and flips each serviced channel's polarity so that the channel drops low again. The next change of that source, in either direction, raises the request once more. The polarity and enable bits sit in two 4-bit registers. These are loaded through a simple write strobe with a one-bit register select, the same style used by the port bank.

Top module: `irqc_combiner`

## Requirements
- R1: While rst_n is low at a clock edge, the block loads all enable bits to 0 and all polarity bits to 1, clears the synchronizer, and drives irq_n_o high.
- R2: A clock edge with wr_en_i high and wr_sel_i = 0 loads wr_data_i into the polarity register. With wr_sel_i = 1 the same edge loads the enable register. The register that is not selected keeps its value.
- R3: lvl_o shows src_i delayed by exactly two clock edges, whatever the polarity and enable settings.
- R4: A channel with polarity bit 1 is active when its synchronized level is 1. A channel with polarity bit 0 is active when its synchronized level is 0.
- R5: A channel whose enable bit is 0 never makes irq_n_o low.
- R6: irq_n_o is low on the edge after one where at least one channel was active, and high on the edge after one where none was. A source change therefore reaches irq_n_o three edges after it is applied, and a register write reaches it two edges after the write.
- R7: While several channels are active at once, irq_n_o stays low as one continuous assertion until the last active channel goes inactive.
- R8: Inverting a serviced channel's polarity deactivates it. A later change of that source in the opposite direction raises irq_n_o again, so both edges of a source can interrupt.
- R9: While wr_en_i is low, wr_sel_i and wr_data_i have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 4 | Raw interrupt source levels (bit 0 of group C on ports 2, 5, 8, 11) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 polarity, 1 enable |
| wr_data_i | input | 4 | Write data, one bit per channel |
| lvl_o | output | 4 | Synchronized source levels for the host to read |
| pol_o | output | 4 | Polarity register (1 = pass level, 0 = invert) |
| en_o | output | 4 | Enable register (1 = channel allowed) |
| irq_n_o | output | 1 | Combined active-low level interrupt request |

## Verification
The bench first steps through a table that mixes polarity, enable and source patterns. This catches a design with the polarity encoding reversed, which would fire on idle sources, and a design whose enable gate leaks, which would assert the request with every enable at 0. Directed cases then count edges through the synchronizer and the output register, so a missing or extra flop shows up as a value one cycle early or late. They also write one register and check the other, and toggle wr_sel_i and wr_data_i with no strobe, to catch a select decoder that corrupts or loads the wrong register. A sequence with two simultaneous sources and staggered polarity flips checks that the request stays low until the last channel is cleared, and that a falling source edge raises it again, as the service routine expects.

// File: rtl/irqc_pkg.sv
// Shared parameters and types for the interrupt channel combiner.
package irqc_pkg;
    localparam int unsigned IRQC_CHANNELS = 4;
    localparam int unsigned IRQC_SYNC_DEPTH = 2;

    // Register select on the write strobe interface.
    typedef enum logic {
        SEL_POLARITY = 1'b0,
        SEL_ENABLE   = 1'b1
    } irqc_sel_e;
endpackage

// File: rtl/irqc_sync.sv
// Multi-flop level synchronizer for a vector of asynchronous sources.
// Assumes each bit is an independent level; no cross-bit coherence is kept.
module irqc_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the source through the chain; clear the chain on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[LAST];

    generate
        if (STAGES == 2) begin : g_chk2
            // R3: output equals the input of two edges earlier
            p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/irqc_ctrl_regs.sv
// Polarity and enable registers, loaded through a strobe with a one-bit select.
// Assumes write data is stable at the clock edge when the strobe is high.
module irqc_ctrl_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic           wr_sel_i,
    input  logic [NCH-1:0] wr_data_i,
    output logic [NCH-1:0] pol_o,
    output logic [NCH-1:0] en_o
);
    logic [NCH-1:0] pol_q;
    logic [NCH-1:0] en_q;
    logic           load_pol;
    logic           load_en;

    // Decode the strobe into one load per register.
    always_comb begin
        load_pol = wr_en_i && (irqc_sel_e'(wr_sel_i) == SEL_POLARITY);
        load_en  = wr_en_i && (irqc_sel_e'(wr_sel_i) == SEL_ENABLE);
    end

    // Polarity register: resets to pass-through on every channel.
    always_ff @(posedge clk) begin
        if (!rst_n)        pol_q <= '1;
        else if (load_pol) pol_q <= wr_data_i;
    end

    // Enable register: resets with every channel masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (load_en) en_q <= wr_data_i;
    end

    assign pol_o = pol_q;
    assign en_o  = en_q;

    // R1: the first edge after reset release shows reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (pol_q == '1 && en_q == '0));
    // R2: a selected write lands in the chosen register only
    p_write_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && !$past(wr_sel_i))
            |-> (pol_q == $past(wr_data_i) && $stable(en_q)));
    p_write_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_sel_i))
            |-> (en_q == $past(wr_data_i) && $stable(pol_q)));
    // R9: without the strobe both registers hold
    p_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en_i)) |-> ($stable(pol_q) && $stable(en_q)));
endmodule

// File: rtl/irqc_channel.sv
// One interrupt channel: polarity select followed by enable gate.
// Assumes lvl_i is already synchronized to clk.
module irqc_channel (
    input  logic lvl_i,
    input  logic pol_i,
    input  logic en_i,
    output logic act_o
);
    logic cond;

    // Polarity 1 passes the level, polarity 0 passes its inverse.
    always_comb begin
        cond  = pol_i ? lvl_i : ~lvl_i;
        act_o = en_i & cond;
    end
endmodule

// File: rtl/irqc_combiner.sv
// Four-channel interrupt combiner with per-channel polarity and enable.
// Synchronizes the sources, conditions each channel, ORs the channels with
// equal priority and registers an active-low level request for the host.
// Assumes the host reads lvl_o to identify changed sources.
module irqc_combiner
    import irqc_pkg::*;
#(
    parameter int unsigned NCH        = IRQC_CHANNELS,
    parameter int unsigned SYNC_DEPTH = IRQC_SYNC_DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] src_i,
    input  logic           wr_en_i,
    input  logic           wr_sel_i,
    input  logic [NCH-1:0] wr_data_i,
    output logic [NCH-1:0] lvl_o,
    output logic [NCH-1:0] pol_o,
    output logic [NCH-1:0] en_o,
    output logic           irq_n_o
);
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] pol_q;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] act;
    logic           any_act;
    logic           irq_n_q;

    irqc_sync #(.WIDTH(NCH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (lvl)
    );

    irqc_ctrl_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .pol_o     (pol_q),
        .en_o      (en_q)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            irqc_channel u_ch (
                .lvl_i (lvl[c]),
                .pol_i (pol_q[c]),
                .en_i  (en_q[c]),
                .act_o (act[c])
            );
        end
    endgenerate

    // Equal-priority merge of all channels.
    always_comb any_act = |act;

    // Registered request so the host sees a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~any_act;
    end

    assign lvl_o   = lvl;
    assign pol_o   = pol_q;
    assign en_o    = en_q;
    assign irq_n_o = irq_n_q;

    // R6: request follows the conditioned levels of the previous edge
    p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_n_o == ($past(en_q & ~(lvl ^ pol_q)) == '0)));
    // R5: with every channel masked the request stays released
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_q) == '0) |-> irq_n_o);
    // R7: an asserted request holds while any channel is still active
    p_single_assert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && any_act) |=> !irq_n_o);
    // R1: request is released right after reset
    p_reset_release_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> irq_n_o);
endmodule

// File: tb/tb_irqc_combiner.sv
module tb_irqc_combiner;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] src_i;
    logic           wr_en_i;
    logic           wr_sel_i;
    logic [NCH-1:0] wr_data_i;
    logic [NCH-1:0] lvl_o;
    logic [NCH-1:0] pol_o;
    logic [NCH-1:0] en_o;
    logic           irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irqc_combiner dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .lvl_o     (lvl_o),
        .pol_o     (pol_o),
        .en_o      (en_o),
        .irq_n_o   (irq_n_o)
    );

    // Vector: {polarity, enable, source, expected irq_n}
    localparam int NVEC = 8;
    localparam logic [12:0] VEC [NVEC] = '{
        {4'hF, 4'hF, 4'h0, 1'b1},
        {4'hF, 4'hF, 4'h5, 1'b0},
        {4'h0, 4'hF, 4'h5, 1'b0},
        {4'h0, 4'h0, 4'h0, 1'b1},
        {4'hA, 4'h3, 4'h3, 1'b0},
        {4'h5, 4'hC, 4'h0, 1'b0},
        {4'hF, 4'h8, 4'h7, 1'b1},
        {4'hC, 4'hF, 4'hC, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [NCH-1:0] data);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        tick();
        wr_en_i   = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        @(negedge clk);
        src_i = 4'hF;
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 4'hF;
        tick(); tick();
        wr_en_i = 1'b0;
        // R1: reset state despite active inputs
        check("R1 pol", pol_o, 4'hF);
        check("R1 en", en_o, 4'h0);
        check("R1 lvl", lvl_o, 4'h0);
        check("R1 irq", irq_n_o, 1'b1);
        src_i = '0;
        rst_n = 1'b1;
        tick(); tick(); tick();

        // Table walk: R4 polarity, R5 enable, R6 combine
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b0, VEC[v][12:9]);
            wr(1'b1, VEC[v][8:5]);
            src_i = VEC[v][4:1];
            tick(); tick(); tick();
            check("R2 table pol", pol_o, VEC[v][12:9]);
            check("R2 table en", en_o, VEC[v][8:5]);
            check("R3 table lvl", lvl_o, VEC[v][4:1]);
            check("R4 R5 R6 table irq", irq_n_o, VEC[v][0]);
        end

        // R2: writing one register leaves the other alone
        wr(1'b0, 4'h6);
        check("R2 pol loaded", pol_o, 4'h6);
        check("R2 en kept", en_o, 4'hF);
        wr(1'b1, 4'h9);
        check("R2 en loaded", en_o, 4'h9);
        check("R2 pol kept", pol_o, 4'h6);

        // R9: no strobe, no change
        wr_en_i = 1'b0;
        wr_sel_i = 1'b0; wr_data_i = 4'h1; tick();
        wr_sel_i = 1'b1; wr_data_i = 4'h2; tick();
        check("R9 pol", pol_o, 4'h6);
        check("R9 en", en_o, 4'h9);

        // R3 / R6: latency of source to level and to request
        wr(1'b0, 4'hF);
        wr(1'b1, 4'h1);
        src_i = 4'h0;
        tick(); tick(); tick();
        check("R6 idle", irq_n_o, 1'b1);
        src_i = 4'h1;
        tick();
        check("R3 lvl after 1 edge", lvl_o, 4'h0);
        tick();
        check("R3 lvl after 2 edges", lvl_o, 4'h1);
        check("R6 irq before 3rd edge", irq_n_o, 1'b1);
        tick();
        check("R6 irq after 3rd edge", irq_n_o, 1'b0);
        // R6: write takes effect two edges after the strobe
        wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 4'h0;
        tick();
        wr_en_i = 1'b0;
        check("R6 irq one edge after write", irq_n_o, 1'b0);
        tick();
        check("R6 irq two edges after write", irq_n_o, 1'b1);

        // R7 / R8: two simultaneous sources, staggered polarity flips
        src_i = 4'h0;
        wr(1'b0, 4'h3);
        wr(1'b1, 4'h3);
        tick(); tick();
        check("R7 quiet start", irq_n_o, 1'b1);
        src_i = 4'h3;
        tick(); tick(); tick();
        check("R7 both active", irq_n_o, 1'b0);
        wr(1'b0, 4'h2);
        tick();
        check("R7 one channel left", irq_n_o, 1'b0);
        wr(1'b0, 4'h0);
        tick();
        check("R7 all serviced", irq_n_o, 1'b1);
        src_i = 4'h2;
        tick(); tick(); tick();
        check("R8 falling edge ch0", irq_n_o, 1'b0);
        check("R8 lvl shows change", lvl_o, 4'h2);

        // R1: reset in mid operation
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R1 mid pol", pol_o, 4'hF);
        check("R1 mid en", en_o, 4'h0);
        check("R1 mid irq", irq_n_o, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule